// File: doc/BRIEF.md
# Isochronous Port Transmit Fetch Controller

This block pulls isochronous packet data for transmission from an external byte-wide memory through an unbuffered 8-bit port. It generates the port clock at half the core clock rate, together with a pointer-reset strobe and an increment enable for the external address counter. It samples one byte at the end of each enabled port-clock period and packs the bytes into 32-bit quadlets, first byte most significant. Each quadlet goes to the link side with a one-cycle valid strobe and a flag that marks the first and last quadlet of a packet.

A block is fetched as a fixed number of packets (`BLK_PKTS`). The external source raises data-ready. The controller answers by dropping done and pulsing the pointer reset. Each packet is then held back until a cycle-start pulse arrives. The packet is fetched in two steps: a four-byte preread whose low `LEN_W` bits give the number of payload quadlets, then that many payload quadlets. When the last packet of the block is complete, done rises, and the source must drop data-ready before it can request another block. An active-low abort input returns the controller to idle on the next clock edge.

Top module: `iso_tx_fetch`

## Requirements
- R1: In reset, and on the clock edge after `dma_rst_ni` is sampled low, `done_o` is 1 and `ptr_inc_o`, `ptr_rst_o` and `quad_valid_o` are 0. During `rst_ni`, `port_clk_o` is 0.
- R2: `port_clk_o` inverts on every core clock edge. `ptr_inc_o`, `ptr_rst_o` and `done_o` change only on edges where `port_clk_o` rises, except during an abort.
- R3: When idle and `data_rdy_i` is seen high at a port-clock rise, `done_o` falls and `ptr_rst_o` rises on that same rise. `ptr_rst_o` stays high for exactly one port-clock period.
- R4: A packet fetch starts only after a `cycle_start_i` pulse that arrives while the controller is waiting for one. Each such pulse starts one packet. A pulse that arrives during a fetch has no effect, so the next packet still waits for a new pulse.
- R5: The preread takes four bytes. It is emitted as the first quadlet of the packet, with the first byte in bits 31:24 and `pkt_flag_o` set. Its bits `LEN_W-1:0` give the number of payload quadlets.
- R6: The payload phase emits exactly that many quadlets, each packed first byte most significant. `pkt_flag_o` is set only on the last one. A length of 0 gives a one-quadlet packet whose flag is set.
- R7: `ptr_inc_o` is high only in the preread and payload phases, and only in periods after a port-clock rise at which `data_rdy_i` was high. The number of periods with `ptr_inc_o` high per block equals the number of bytes fetched. A low `data_rdy_i` stalls the fetch without losing a byte.
- R8: After `BLK_PKTS` packets, `done_o` rises and stays high. No pointer reset or new block follows while `data_rdy_i` stays high. A new block needs `data_rdy_i` low and then high again.
- R9: `dma_rst_ni` low aborts a block in flight. After the abort no quadlet appears, and the next block starts over with a pointer reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_rst_ni | input | 1 | Transmit abort, active low, synchronous |
| cycle_start_i | input | 1 | Cycle-start pulse, one core clock wide |
| data_rdy_i | input | 1 | External source has block data ready |
| port_data_i | input | 8 | Byte from the external memory |
| port_clk_o | output | 1 | Port clock, core clock divided by two |
| ptr_rst_o | output | 1 | External address pointer reset |
| ptr_inc_o | output | 1 | External address increment enable |
| done_o | output | 1 | Low while a block is in progress |
| quad_valid_o | output | 1 | Quadlet strobe, one core clock wide |
| quad_data_o | output | 32 | Packed quadlet |
| pkt_flag_o | output | 1 | First or last quadlet of a packet, valid with the strobe |

## Verification
A drop of data-ready can coincide with the port-clock rise at which the fourth byte of a quadlet is captured, and with that the phase change from preread to payload or the end of a packet. The bench provokes this with random stalls drawn on every port period across random packet lengths. A scoreboard of quadlets and flags, built from the memory image, judges the result, along with a count of enabled periods against the bytes the packets hold. A second collision is a cycle-start pulse that lands while a payload phase is running. It is placed directly after a preread and judged by checking that the following packet stays unfetched until a fresh pulse.

// File: rtl/iso_tx_pkg.sv
package iso_tx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RST,
    S_WAIT,
    S_PRE,
    S_DATA,
    S_EOB
  } fetch_state_e;

  localparam int unsigned QUAD_BYTES = 4;
endpackage

// File: rtl/iso_port_clkgen.sv
module iso_port_clkgen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic port_clk_o,
  output logic tick_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  // edges with ph_q low are the port-clock rises
  assign tick_o     = ~ph_q;
  assign port_clk_o = ph_q;
endmodule

// File: rtl/iso_byte_packer.sv
module iso_byte_packer #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned QB     = iso_tx_pkg::QUAD_BYTES,
  localparam int unsigned QW    = BYTE_W * QB,
  localparam int unsigned BPW   = (QB > 1) ? $clog2(QB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [QW-1:0]     word_o,
  output logic              full_o
);
  logic [QW-BYTE_W-1:0] sh_q;
  logic [BPW-1:0]       bpos_q;

  assign word_o = {sh_q, byte_i};
  assign full_o = cap_i && (bpos_q == BPW'(QB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bpos_q <= '0;
    end else if (clr_i) begin
      sh_q   <= '0;
      bpos_q <= '0;
    end else if (cap_i) begin
      sh_q   <= word_o[QW-BYTE_W-1:0];
      bpos_q <= full_o ? '0 : bpos_q + 1'b1;
    end
  end
endmodule

// File: rtl/iso_fetch_fsm.sv
module iso_fetch_fsm
  import iso_tx_pkg::*;
#(
  parameter int unsigned QW       = 32,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned BLK_PKTS = 2,
  localparam int unsigned PW      = (BLK_PKTS > 1) ? $clog2(BLK_PKTS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dma_rst_ni,
  input  logic          tick_i,
  input  logic          data_rdy_i,
  input  logic          cycle_start_i,
  input  logic          full_i,
  input  logic [QW-1:0] word_i,
  output logic          inc_o,
  output logic          ptr_rst_o,
  output logic          done_o,
  output logic          q_valid_o,
  output logic [QW-1:0] q_data_o,
  output logic          pkt_flag_o
);
  localparam logic [PW-1:0] LAST_PKT = PW'(BLK_PKTS - 1);

  fetch_state_e     state_q, nstate;
  logic             cyc_pend_q, pend_d;
  logic [LEN_W-1:0] qrem_q, qrem_d;
  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic             emit, flag, pkt_end, fetch_d;

  always_comb begin
    nstate  = state_q;
    qrem_d  = qrem_q;
    pcnt_d  = pcnt_q;
    emit    = 1'b0;
    flag    = 1'b0;
    pkt_end = 1'b0;
    // cycle starts count only while waiting for one
    if (state_q != S_WAIT)  pend_d = 1'b0;
    else if (cycle_start_i) pend_d = 1'b1;
    else                    pend_d = cyc_pend_q;
    if (tick_i) begin
      case (state_q)
        S_IDLE: if (data_rdy_i) nstate = S_RST;
        S_RST:  nstate = S_WAIT;
        S_WAIT: if (pend_d) begin
          nstate = S_PRE;
          pend_d = 1'b0;
        end
        S_PRE: if (full_i) begin
          emit = 1'b1;
          flag = 1'b1;
          if (word_i[LEN_W-1:0] == '0) pkt_end = 1'b1;
          else begin
            qrem_d = word_i[LEN_W-1:0];
            nstate = S_DATA;
          end
        end
        S_DATA: if (full_i) begin
          emit   = 1'b1;
          qrem_d = qrem_q - 1'b1;
          if (qrem_q == LEN_W'(1)) begin
            flag    = 1'b1;
            pkt_end = 1'b1;
          end
        end
        S_EOB:   if (!data_rdy_i) nstate = S_IDLE;
        default: nstate = S_IDLE;
      endcase
      if (pkt_end) begin
        if (pcnt_q == LAST_PKT) begin
          pcnt_d = '0;
          nstate = S_EOB;
        end else begin
          pcnt_d = pcnt_q + 1'b1;
          nstate = S_WAIT;
        end
      end
    end
  end

  assign fetch_d = (nstate == S_PRE) || (nstate == S_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cyc_pend_q <= 1'b0;
      qrem_q     <= '0;
      pcnt_q     <= '0;
      inc_o      <= 1'b0;
      ptr_rst_o  <= 1'b0;
      done_o     <= 1'b1;
      q_valid_o  <= 1'b0;
      q_data_o   <= '0;
      pkt_flag_o <= 1'b0;
    end else if (!dma_rst_ni) begin
      state_q    <= S_IDLE;
      cyc_pend_q <= 1'b0;
      qrem_q     <= '0;
      pcnt_q     <= '0;
      inc_o      <= 1'b0;
      ptr_rst_o  <= 1'b0;
      done_o     <= 1'b1;
      q_valid_o  <= 1'b0;
      pkt_flag_o <= 1'b0;
    end else begin
      cyc_pend_q <= pend_d;
      q_valid_o  <= emit;
      pkt_flag_o <= flag;
      if (emit) q_data_o <= word_i;
      if (tick_i) begin
        state_q   <= nstate;
        qrem_q    <= qrem_d;
        pcnt_q    <= pcnt_d;
        inc_o     <= fetch_d && data_rdy_i;
        ptr_rst_o <= (nstate == S_RST);
        done_o    <= (nstate == S_IDLE) || (nstate == S_EOB);
      end
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dma_rst_ni |=> (done_o && !inc_o && !q_valid_o)); // R9
  AST_OUT_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && dma_rst_ni) |=> ($stable(inc_o) && $stable(ptr_rst_o) && $stable(done_o))); // R2
  AST_PTR_RST_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_rst_o && tick_i) |=> !ptr_rst_o); // R3
  AST_NO_INC_WHEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_o && done_o)); // R7
  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !cyc_pend_q && !cycle_start_i && dma_rst_ni) |=> !inc_o); // R4
  AST_FLAG_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_flag_o |-> q_valid_o); // R5
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_valid_o |=> !q_valid_o); // R6
  AST_EOB_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EOB && data_rdy_i && dma_rst_ni) |=> (!ptr_rst_o && done_o)); // R8
endmodule

// File: rtl/iso_tx_fetch.sv
module iso_tx_fetch #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned BLK_PKTS = 2,
  localparam int unsigned QW      = BYTE_W * iso_tx_pkg::QUAD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_rst_ni,
  input  logic              cycle_start_i,
  input  logic              data_rdy_i,
  input  logic [BYTE_W-1:0] port_data_i,
  output logic              port_clk_o,
  output logic              ptr_rst_o,
  output logic              ptr_inc_o,
  output logic              done_o,
  output logic              quad_valid_o,
  output logic [QW-1:0]     quad_data_o,
  output logic              pkt_flag_o
);
  logic          tick;
  logic          cap;
  logic          full;
  logic [QW-1:0] word;

  iso_port_clkgen u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_clk_o (port_clk_o),
    .tick_o     (tick)
  );

  // a byte is taken at the rise that closes an enabled period
  assign cap = tick && ptr_inc_o;

  iso_byte_packer #(
    .BYTE_W (BYTE_W),
    .QB     (iso_tx_pkg::QUAD_BYTES)
  ) u_packer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!dma_rst_ni),
    .cap_i  (cap),
    .byte_i (port_data_i),
    .word_o (word),
    .full_o (full)
  );

  iso_fetch_fsm #(
    .QW       (QW),
    .LEN_W    (LEN_W),
    .BLK_PKTS (BLK_PKTS)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .dma_rst_ni    (dma_rst_ni),
    .tick_i        (tick),
    .data_rdy_i    (data_rdy_i),
    .cycle_start_i (cycle_start_i),
    .full_i        (full),
    .word_i        (word),
    .inc_o         (ptr_inc_o),
    .ptr_rst_o     (ptr_rst_o),
    .done_o        (done_o),
    .q_valid_o     (quad_valid_o),
    .q_data_o      (quad_data_o),
    .pkt_flag_o    (pkt_flag_o)
  );
endmodule

// File: tb/iso_tx_fetch_tb.sv
`timescale 1ns/1ps
module iso_tx_fetch_tb;
  localparam int BLK = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dma_rst_n = 1'b1;
  logic cyc = 1'b0;
  logic rdy_req = 1'b0;
  logic stall_now = 1'b0;
  logic stall_en = 1'b0;
  logic [7:0] mem [0:255];
  int ptr = 0;
  logic [7:0] pdata;
  logic data_rdy;

  logic port_clk, ptr_rst, ptr_inc, done, qv, pflag;
  logic [31:0] qdata;

  assign pdata    = mem[ptr[7:0]];
  assign data_rdy = rdy_req && !stall_now;

  iso_tx_fetch #(.BYTE_W(8), .LEN_W(8), .BLK_PKTS(BLK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dma_rst_ni(dma_rst_n), .cycle_start_i(cyc),
    .data_rdy_i(data_rdy), .port_data_i(pdata), .port_clk_o(port_clk),
    .ptr_rst_o(ptr_rst), .ptr_inc_o(ptr_inc), .done_o(done),
    .quad_valid_o(qv), .quad_data_o(qdata), .pkt_flag_o(pflag)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int rx_cnt = 0, fetched = 0, r2_bad = 0, mon_skip = 2;
  int tot_bytes = 0;
  logic [32:0] exp_q [$];
  bit exp_hdr [$];
  logic [32:0] e;
  bit eh;
  logic pclk_prev = 1'b0, pinc = 1'b0, prst = 1'b0, pdone = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] make_hdr(input int len);
    logic [31:0] w;
    w = $urandom();
    w[7:0] = 8'(len);
    return w;
  endfunction

  // memory model, scoreboard, port-clock rule watcher
  always @(negedge clk) begin
    if (port_clk && !pclk_prev) begin
      if (prst) ptr = 0;
      else if (pinc) begin
        ptr = ptr + 1;
        fetched = fetched + 1;
      end
    end
    if (rst_n) begin
      if (!dma_rst_n) mon_skip = 3;
      if (mon_skip > 0) mon_skip = mon_skip - 1;
      else begin
        if (port_clk == pclk_prev) r2_bad = r2_bad + 1;
        if (!(port_clk && !pclk_prev) && ({ptr_inc, ptr_rst, done} != {pinc, prst, pdone}))
          r2_bad = r2_bad + 1;
      end
      if (qv) begin
        rx_cnt = rx_cnt + 1;
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected quadlet", {31'b0, pflag, qdata}, 64'h0);
        else begin
          e  = exp_q.pop_front();
          eh = exp_hdr.pop_front();
          chk(qdata == e[31:0], eh ? "R5 preread quadlet" : "R6 payload quadlet", qdata, e[31:0]);
          chk(pflag == e[32], eh ? "R5 first flag" : "R6 last flag", pflag, e[32]);
        end
      end
      stall_now = stall_en && !done && (($urandom() % 3) == 0);
    end
    pclk_prev = port_clk;
    pinc = ptr_inc;
    prst = ptr_rst;
    pdone = done;
  end

  task automatic build_block(input int lens [BLK]);
    int a;
    logic [31:0] w;
    a = 0;
    exp_q.delete();
    exp_hdr.delete();
    for (int p = 0; p < BLK; p++) begin
      for (int q = 0; q <= lens[p]; q++) begin
        w = (q == 0) ? make_hdr(lens[p]) : $urandom();
        for (int b = 0; b < 4; b++) begin
          mem[a] = w[31-8*b -: 8];
          a = a + 1;
        end
        exp_q.push_back({(q == 0) || (q == lens[p]), w});
        exp_hdr.push_back(q == 0);
      end
    end
    tot_bytes = a;
  endtask

  task automatic wait_cnt(input int target);
    for (int i = 0; i < 4000 && rx_cnt < target; i++) @(negedge clk);
  endtask

  task automatic run_block(input int lens [BLK], input bit stall, input bit extra_pulse);
    int target;
    bit seen;
    build_block(lens);
    fetched = 0;
    stall_en = stall;
    target = rx_cnt;
    @(negedge clk) rdy_req = 1'b1;
    for (int i = 0; i < 20 && done; i++) @(negedge clk);
    chk(!done, "R3 done falls on request", done, 0);
    chk(ptr_rst, "R3 pointer reset with done low", ptr_rst, 1);
    @(negedge clk);
    chk(ptr_rst, "R3 pointer reset held one period", ptr_rst, 1);
    @(negedge clk);
    chk(!ptr_rst, "R3 pointer reset ends after one period", ptr_rst, 0);
    for (int p = 0; p < BLK; p++) begin
      repeat (12) @(negedge clk);
      chk(rx_cnt == target && !ptr_inc, "R4 no fetch before cycle start", rx_cnt, target);
      cyc = 1'b1;
      @(negedge clk) cyc = 1'b0;
      if (extra_pulse && p == 0) begin
        wait_cnt(target + 1);
        cyc = 1'b1;
        @(negedge clk) cyc = 1'b0;
      end
      target = target + lens[p] + 1;
      wait_cnt(target);
      chk(rx_cnt == target, "R6 packet quadlet count", rx_cnt, target);
    end
    for (int i = 0; i < 20 && !done; i++) @(negedge clk);
    chk(done, "R8 done rises after last packet", done, 1);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ptr_rst || !done) seen = 1'b1;
    end
    chk(!seen, "R8 no new block while ready stays high", seen, 0);
    chk(fetched == tot_bytes, "R7 enabled periods equal bytes", fetched, tot_bytes);
    chk(exp_q.size() == 0, "R6 all quadlets delivered", exp_q.size(), 0);
    rdy_req = 1'b0;
    stall_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    int lens [BLK];
    int rx0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    chk(done && !ptr_inc && !ptr_rst && !qv && !port_clk, "R1 reset state",
        {done, ptr_inc, ptr_rst, qv, port_clk}, 5'b10000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(done && !ptr_inc && !ptr_rst, "R1 idle after reset", {done, ptr_inc, ptr_rst}, 3'b100);

    void'($urandom(32'h1394_5eed));
    run_block('{3, 0}, 1'b0, 1'b1);  // R4 stray pulse in payload, R6 zero length
    run_block('{0, 0}, 1'b0, 1'b0);
    run_block('{1, 4}, 1'b1, 1'b0);  // R7 stalls
    for (int b = 0; b < 6; b++) begin
      for (int p = 0; p < BLK; p++) lens[p] = $urandom() % 5;
      run_block(lens, 1'b1, 1'b0);
    end

    // R9 abort in the middle of a block
    build_block('{4, 4});
    @(negedge clk) rdy_req = 1'b1;
    for (int i = 0; i < 20 && done; i++) @(negedge clk);
    repeat (12) @(negedge clk);
    cyc = 1'b1;
    @(negedge clk) cyc = 1'b0;
    wait_cnt(rx_cnt + 2);
    @(negedge clk);
    dma_rst_n = 1'b0;
    rdy_req = 1'b0;
    @(negedge clk);
    chk(done && !ptr_inc && !ptr_rst && !qv, "R9 abort idles at once",
        {done, ptr_inc, ptr_rst, qv}, 4'b1000);
    repeat (2) @(negedge clk);
    dma_rst_n = 1'b1;
    exp_q.delete();
    exp_hdr.delete();
    rx0 = rx_cnt;
    repeat (30) @(negedge clk);
    chk(rx_cnt == rx0 && done, "R9 nothing emitted after abort", rx_cnt, rx0);
    run_block('{2, 1}, 1'b1, 1'b0);  // R9 restart from pointer reset

    chk(r2_bad == 0, "R2 port clock and output timing", r2_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule